// File: doc/BRIEF.md
# Shared Interrupt Router

This block takes a set of shared external interrupt inputs and delivers them to the local interrupt inputs of every core in a multicore cluster. Each shared input has three pieces of configuration of its own: a destination core mask, a mode word (the distribution policy and the trigger type), and a mask bit. Software writes all of them through a single-cycle command port. Each command carries a code, an interrupt index and a 32-bit data word. A separate command switches the whole router on. Until that command arrives, no core sees anything.

Each shared input picks its cores by its own policy. It can go to one fixed core, the lowest set bit of its mask. It can go to every core in its mask at once. Or it can rotate, so that each new assertion moves to the next core in the mask. Level inputs are forwarded for as long as the input stays high. Edge inputs leave a pending bit toward each chosen core, and that bit holds until the core acknowledges it. The output is one vector per core, with one line per shared input. Each core wires that vector to its local interrupt numbers from 24 upward.

Top module: `shared_irq_router`

## Requirements
- R1: After reset, every output line is 0. Every shared input is masked, every destination mask is 0 and the global enable is off.
- R2: No output line rises until a command with code 1 (enable) has been accepted. The command's index and data are don't-care.
- R3: A command with code 4 writes data bit 0 as the mask bit of the indexed input: 1 masks it and 0 unmasks it. A masked input drives no output line, and a rising edge on it while it is masked is neither captured nor advances the rotation.
- R4: A command with code 2 writes data bits [NUM_CORES-1:0] as the destination mask of the indexed input, with bit c standing for core c. An input never drives a core whose mask bit is 0, and an empty mask delivers nowhere.
- R5: A command with code 3 writes the mode of the indexed input. Data bits [1:0] select the policy and data bit 4 selects the trigger, 1 for level and 0 for edge. Every other data bit has no effect.
- R6: Policy 2, and also policy 3, delivers only to the core given by the lowest set bit of the destination mask.
- R7: Policy 1 delivers to every core whose bit is set in the destination mask, all at the same time.
- R8: Policy 0 sends each new assertion to the next set bit of the destination mask after the last core chosen, wrapping from the top core to core 0. The first assertion after reset goes to the lowest set bit.
- R9: In level mode, the chosen core's line stays high for as long as the input stays high. The line drops one cycle after the input falls.
- R10: In edge mode, a rising edge sets a pending line toward each chosen core. That line stays high after the input falls, and it clears when ackIn for that core and that input is held for a cycle.
- R11: Output bit c*NUM_IRQ+i is shared input i at core c, which the core sees as local interrupt 24+i. ackIn uses the same layout. Outputs are registered and follow their inputs by one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | A command is present this cycle |
| cmdCode | input | 3 | 1 enable, 2 destination, 3 mode, 4 mask |
| cmdIndex | input | $clog2(NUM_IRQ) | Shared input the command addresses |
| cmdData | input | 32 | Command data word |
| irqIn | input | NUM_IRQ | Shared interrupt inputs |
| ackIn | input | NUM_CORES*NUM_IRQ | Per-core acknowledge of edge pending lines |
| coreIrq | output | NUM_CORES*NUM_IRQ | Per-core interrupt lines |

## Verification
A rotation pointer that is stuck or skips a core shows up on the very next rising assertion of that input, as a line appearing at the wrong core. The bench therefore checks several pulses in a row on a single input. A pending bit that is cleared by the wrong acknowledge, or that is never set, shows up one cycle after the ack or the edge, because both the drop and the persistence of the line are checked. A mask or enable bit that is decoded wrongly lets a line through within one cycle. A rising edge that was captured while masked only shows up at the next unmasked assertion, where the core that gets chosen differs from the expected one.

// File: rtl/irqdist_pkg.sv
package irqdist_pkg;

  typedef enum logic [2:0] {
    CMD_NOP      = 3'd0,
    CMD_ENABLE   = 3'd1,
    CMD_SET_DEST = 3'd2,
    CMD_SET_MODE = 3'd3,
    CMD_SET_MASK = 3'd4
  } cmd_code_e;

  typedef enum logic [1:0] {
    POL_ROTATE  = 2'd0,
    POL_BCAST   = 2'd1,
    POL_SINGLE  = 2'd2,
    POL_SINGLE3 = 2'd3
  } dist_pol_e;

  localparam int LVL_BIT    = 4;
  localparam int LOCAL_BASE = 24;
  localparam int DATA_W     = 32;

  typedef struct packed {
    logic enable;
    logic wrDest;
    logic wrMode;
    logic wrMask;
  } cfg_strobe_t;

endpackage

// File: rtl/irqdist_cmd_ctrl.sv
module irqdist_cmd_ctrl
  import irqdist_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmdValid,
  input  logic [2:0]  cmdCode,
  output cfg_strobe_t strobe,
  output logic        globalEn
);

  always_comb begin
    strobe = '0;
    if (cmdValid) begin
      unique case (cmd_code_e'(cmdCode))
        CMD_ENABLE:   strobe.enable = 1'b1;
        CMD_SET_DEST: strobe.wrDest = 1'b1;
        CMD_SET_MODE: strobe.wrMode = 1'b1;
        CMD_SET_MASK: strobe.wrMask = 1'b1;
        default:      strobe = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)             globalEn <= 1'b0;
    else if (strobe.enable) globalEn <= 1'b1;
  end

endmodule

// File: rtl/irqdist_lane.sv
module irqdist_lane
  import irqdist_pkg::*;
#(
  parameter int NUM_CORES = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 globalEn,
  input  logic                 wrDest,
  input  logic                 wrMode,
  input  logic                 wrMask,
  input  logic [NUM_CORES-1:0] destData,
  input  logic [1:0]           polData,
  input  logic                 lvlData,
  input  logic                 maskData,
  input  logic                 irqIn,
  input  logic [NUM_CORES-1:0] ackIn,
  output logic [NUM_CORES-1:0] laneOut,
  output logic [NUM_CORES-1:0] destQ,
  output logic [1:0]           polQ,
  output logic                 lvlQ,
  output logic                 maskQ
);

  localparam int CW = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1;
  localparam logic [NUM_CORES-1:0] ONE = {{(NUM_CORES-1){1'b0}}, 1'b1};

  logic                 prevIn;
  logic [CW-1:0]        rrQ;
  logic [CW-1:0]        rrPick;
  logic [NUM_CORES-1:0] pendQ;
  logic [NUM_CORES-1:0] pendNext;
  logic [NUM_CORES-1:0] target;
  logic [NUM_CORES-1:0] outNext;
  logic                 active;
  logic                 rise;

  function automatic logic [CW-1:0] nextCore(input logic [CW-1:0] cur,
                                             input logic [NUM_CORES-1:0] d);
    logic [CW-1:0] r;
    logic          found;
    r     = cur;
    found = 1'b0;
    for (int off = 1; off <= NUM_CORES; off++) begin
      int idx;
      idx = (int'(cur) + off) % NUM_CORES;
      if (!found && d[idx]) begin
        r     = CW'(idx);
        found = 1'b1;
      end
    end
    return r;
  endfunction

  assign active = globalEn & ~maskQ;
  assign rise   = irqIn & ~prevIn;

  always_comb begin
    rrPick = rrQ;
    if (active && rise && dist_pol_e'(polQ) == POL_ROTATE)
      rrPick = nextCore(rrQ, destQ);
    unique case (dist_pol_e'(polQ))
      POL_ROTATE: target = destQ & (ONE << rrPick);
      POL_BCAST:  target = destQ;
      default:    target = destQ & (~destQ + ONE);
    endcase
    pendNext = (pendQ & ~ackIn) | ({NUM_CORES{active & rise & ~lvlQ}} & target);
    if (lvlQ) outNext = {NUM_CORES{active & irqIn}} & target;
    else      outNext = {NUM_CORES{active}} & pendNext;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      destQ   <= '0;
      polQ    <= POL_SINGLE;
      lvlQ    <= 1'b1;
      maskQ   <= 1'b1;
      prevIn  <= 1'b0;
      rrQ     <= CW'(NUM_CORES - 1);
      pendQ   <= '0;
      laneOut <= '0;
    end else begin
      if (wrDest) destQ <= destData;
      if (wrMode) begin
        polQ <= polData;
        lvlQ <= lvlData;
      end
      if (wrMask) maskQ <= maskData;
      prevIn  <= irqIn;
      rrQ     <= rrPick;
      pendQ   <= pendNext;
      laneOut <= outNext;
    end
  end

endmodule

// File: rtl/irqdist_datapath.sv
module irqdist_datapath
  import irqdist_pkg::*;
#(
  parameter int NUM_IRQ   = 8,
  parameter int NUM_CORES = 4,
  localparam int IW = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1,
  localparam int TOT = NUM_IRQ * NUM_CORES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cfg_strobe_t       strobe,
  input  logic              globalEn,
  input  logic [IW-1:0]     cmdIndex,
  input  logic [DATA_W-1:0] cmdData,
  input  logic [NUM_IRQ-1:0] irqIn,
  input  logic [TOT-1:0]    ackIn,
  output logic [TOT-1:0]    coreIrq,
  output logic [TOT-1:0]    destFlat,
  output logic [2*NUM_IRQ-1:0] polFlat,
  output logic [NUM_IRQ-1:0] lvlVec,
  output logic [NUM_IRQ-1:0] maskVec
);

  logic unusedData;
  assign unusedData = ^cmdData;

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_lane
    logic                 hit;
    logic [NUM_CORES-1:0] laneAck;
    logic [NUM_CORES-1:0] laneOut;

    assign hit = (cmdIndex == IW'(i));

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
      assign laneAck[c]             = ackIn[c*NUM_IRQ + i];
      assign coreIrq[c*NUM_IRQ + i] = laneOut[c];
    end

    irqdist_lane #(.NUM_CORES(NUM_CORES)) u_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .globalEn (globalEn),
      .wrDest   (strobe.wrDest & hit),
      .wrMode   (strobe.wrMode & hit),
      .wrMask   (strobe.wrMask & hit),
      .destData (cmdData[NUM_CORES-1:0]),
      .polData  (cmdData[1:0]),
      .lvlData  (cmdData[LVL_BIT]),
      .maskData (cmdData[0]),
      .irqIn    (irqIn[i]),
      .ackIn    (laneAck),
      .laneOut  (laneOut),
      .destQ    (destFlat[i*NUM_CORES +: NUM_CORES]),
      .polQ     (polFlat[2*i +: 2]),
      .lvlQ     (lvlVec[i]),
      .maskQ    (maskVec[i])
    );
  end

endmodule

// File: rtl/shared_irq_router.sv
module shared_irq_router
  import irqdist_pkg::*;
#(
  parameter int NUM_IRQ   = 8,
  parameter int NUM_CORES = 4,
  localparam int IW = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1,
  localparam int TOT = NUM_IRQ * NUM_CORES
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmdValid,
  input  logic [2:0]         cmdCode,
  input  logic [IW-1:0]      cmdIndex,
  input  logic [31:0]        cmdData,
  input  logic [NUM_IRQ-1:0] irqIn,
  input  logic [TOT-1:0]     ackIn,
  output logic [TOT-1:0]     coreIrq
);

  cfg_strobe_t           strobe;
  logic                  globalEn;
  logic [TOT-1:0]        destFlat;
  logic [2*NUM_IRQ-1:0]  polFlat;
  logic [NUM_IRQ-1:0]    lvlVec;
  logic [NUM_IRQ-1:0]    maskVec;

  irqdist_cmd_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmdValid (cmdValid),
    .cmdCode  (cmdCode),
    .strobe   (strobe),
    .globalEn (globalEn)
  );

  irqdist_datapath #(.NUM_IRQ(NUM_IRQ), .NUM_CORES(NUM_CORES)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (strobe),
    .globalEn (globalEn),
    .cmdIndex (cmdIndex),
    .cmdData  (cmdData),
    .irqIn    (irqIn),
    .ackIn    (ackIn),
    .coreIrq  (coreIrq),
    .destFlat (destFlat),
    .polFlat  (polFlat),
    .lvlVec   (lvlVec),
    .maskVec  (maskVec)
  );

endmodule

// File: rtl/irqdist_checker.sv
module irqdist_checker #(
  parameter int NI = 8,
  parameter int NC = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             globalEn,
  input logic [NI-1:0]    maskVec,
  input logic [NI*NC-1:0] destFlat,
  input logic [2*NI-1:0]  polFlat,
  input logic [NI-1:0]    lvlVec,
  input logic [NI-1:0]    irqIn,
  input logic [NI*NC-1:0] coreIrq
);

  // R2
  globalen_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !globalEn |=> coreIrq == '0);

  for (genvar i = 0; i < NI; i++) begin : g_chk
    logic [NC-1:0] col;
    for (genvar c = 0; c < NC; c++) begin : g_col
      assign col[c] = coreIrq[c*NI + i];
    end

    // R3
    mask_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      maskVec[i] |=> col == '0);

    // R6
    single_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lvlVec[i] && polFlat[2*i +: 2] != 2'd1) |=> $onehot0(col));

    // R4
    dest_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lvlVec[i] |=> (col & ~$past(destFlat[i*NC +: NC])) == '0);

    // R9
    level_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lvlVec[i] && !irqIn[i]) |=> col == '0);
  end

endmodule

bind shared_irq_router irqdist_checker #(.NI(NUM_IRQ), .NC(NUM_CORES)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .globalEn (globalEn),
  .maskVec  (maskVec),
  .destFlat (destFlat),
  .polFlat  (polFlat),
  .lvlVec   (lvlVec),
  .irqIn    (irqIn),
  .coreIrq  (coreIrq)
);

// File: tb/test_shared_irq_router.sv
`timescale 1ns/1ps
module test_shared_irq_router;

  localparam int NI  = 8;
  localparam int NC  = 4;
  localparam int TOT = NI * NC;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           cmdValid = 1'b0;
  logic [2:0]     cmdCode = '0;
  logic [2:0]     cmdIndex = '0;
  logic [31:0]    cmdData = '0;
  logic [NI-1:0]  irqIn = '0;
  logic [TOT-1:0] ackIn = '0;
  logic [TOT-1:0] coreIrq;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  shared_irq_router #(.NUM_IRQ(NI), .NUM_CORES(NC)) i_shared_irq_router (
    .clk(clk), .rst_n(rst_n), .cmdValid(cmdValid), .cmdCode(cmdCode),
    .cmdIndex(cmdIndex), .cmdData(cmdData), .irqIn(irqIn),
    .ackIn(ackIn), .coreIrq(coreIrq)
  );

  // {index[12:10], policy[9:8], dest[7:4], expected cores[3:0]}, level mode
  localparam logic [12:0] VEC [6] = '{
    {3'd0, 2'd2, 4'b0110, 4'b0010},
    {3'd1, 2'd1, 4'b1011, 4'b1011},
    {3'd2, 2'd3, 4'b1100, 4'b0100},
    {3'd3, 2'd0, 4'b1010, 4'b0010},
    {3'd4, 2'd1, 4'b0000, 4'b0000},
    {3'd5, 2'd0, 4'b1000, 4'b1000}
  };

  function automatic logic [NC-1:0] col(input int i);
    logic [NC-1:0] r;
    for (int c = 0; c < NC; c++) r[c] = coreIrq[c*NI + i];
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic cmd(input logic [2:0] code, input int idx, input logic [31:0] data);
    cmdValid = 1'b1;
    cmdCode  = code;
    cmdIndex = 3'(idx);
    cmdData  = data;
    step();
    cmdValid = 1'b0;
    cmdData  = '0;
  endtask

  task automatic pulse(input int idx);
    irqIn[idx] = 1'b1;
    step();
    irqIn[idx] = 1'b0;
    step();
  endtask

  task automatic ack(input int core, input int idx);
    ackIn[core*NI + idx] = 1'b1;
    step();
    ackIn[core*NI + idx] = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [TOT-1:0] flat;
    repeat (3) step();
    rst_n = 1'b1;
    step();
    check("R1 reset outputs", coreIrq, '0);

    // irq6: broadcast, level, all cores, unmasked, before enable
    cmd(3'd2, 6, 32'hF);
    cmd(3'd3, 6, 32'h11);
    cmd(3'd4, 6, 32'h0);
    irqIn[6] = 1'b1;
    step(); step();
    check("R2 no delivery before enable", coreIrq, '0);
    cmd(3'd1, 0, 32'h0);
    step();
    flat = '0;
    for (int c = 0; c < NC; c++) flat[c*NI + 6] = 1'b1;
    check("R11 output layout core*NUM_IRQ+i", coreIrq, flat);

    cmd(3'd4, 6, 32'h1);
    step();
    check("R3 masked input silent", 32'(col(6)), 32'h0);
    cmd(3'd4, 6, 32'h0);
    step();
    check("R3 unmask restores delivery", 32'(col(6)), 32'hF);
    irqIn[6] = 1'b0;
    step();
    check("R9 level drops with input", 32'(col(6)), 32'h0);

    for (int e = 0; e < 6; e++) begin
      int idx;
      string tag;
      idx = int'(VEC[e][12:10]);
      case (VEC[e][9:8])
        2'd0:    tag = "R8 rotate first pick";
        2'd1:    tag = (VEC[e][7:4] == 4'b0) ? "R4 empty mask" : "R7 broadcast";
        default: tag = "R6 single lowest bit";
      endcase
      cmd(3'd2, idx, 32'(VEC[e][7:4]));
      cmd(3'd3, idx, {28'h0, 2'b01, VEC[e][9:8]} | 32'h10);
      cmd(3'd4, idx, 32'h0);
      irqIn[idx] = 1'b1;
      step();
      check(tag, 32'(col(idx)), 32'(VEC[e][3:0]));
      irqIn[idx] = 1'b0;
      step();
      check("R9 drop after table entry", 32'(col(idx)), 32'h0);
    end

    // irq3 rotate over 1010, last pick core1
    irqIn[3] = 1'b1; step();
    check("R8 rotate to core3", 32'(col(3)), 32'b1000);
    irqIn[3] = 1'b0; step();
    irqIn[3] = 1'b1; step();
    check("R8 rotate wraps to core1", 32'(col(3)), 32'b0010);
    irqIn[3] = 1'b0; step();
    irqIn[3] = 1'b1; step();
    for (int k = 0; k < 3; k++) begin
      check("R9 level hold on core3", 32'(col(3)), 32'b1000);
      step();
    end
    irqIn[3] = 1'b0; step();

    // R5: junk in unused bits, policy 1 level
    cmd(3'd3, 2, 32'hABCD_EE11);
    irqIn[2] = 1'b1; step();
    check("R5 other mode bits ignored", 32'(col(2)), 32'b1100);
    irqIn[2] = 1'b0; step();

    // R10 edge broadcast on irq7
    cmd(3'd2, 7, 32'h5);
    cmd(3'd3, 7, 32'h1);
    cmd(3'd4, 7, 32'h0);
    pulse(7);
    check("R10 pending holds after edge", 32'(col(7)), 32'b0101);
    ack(0, 7); step();
    check("R10 ack clears core0 only", 32'(col(7)), 32'b0100);
    ack(2, 7); step();
    check("R10 ack clears core2", 32'(col(7)), 32'b0000);

    // edge rotate over 0110
    cmd(3'd2, 7, 32'h6);
    cmd(3'd3, 7, 32'h0);
    pulse(7);
    check("R8 edge rotate first pick", 32'(col(7)), 32'b0010);
    pulse(7);
    check("R10 second edge adds core2", 32'(col(7)), 32'b0110);
    cmd(3'd4, 7, 32'h1);
    pulse(7);
    check("R3 masked hides pending", 32'(col(7)), 32'b0000);
    cmd(3'd4, 7, 32'h0);
    step();
    check("R10 pending kept across mask", 32'(col(7)), 32'b0110);
    ack(1, 7); ack(2, 7); step();
    check("R10 both acks clear", 32'(col(7)), 32'b0000);
    pulse(7);
    check("R3 masked edge did not rotate", 32'(col(7)), 32'b0010);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule